// File: doc/BRIEF.md
# Second-Level Cache Allocation Policy Filter

This block decides what a unified second-level cache does with each request that reaches it. A request names its source: an instruction fetch, a data load or store, or a line cast out of the first-level data cache. It also carries the lookup result (hit or miss), the cast-out line's coherence bit, and a write flag. The filter answers three questions. Does the request allocate a new line? Must the request also appear on the system bus? Is the written line marked dirty?

Five static control inputs shape the answers:
- an enable;
- a data-only lock, which lets only data-side traffic allocate;
- an instruction-only lock, which lets only instruction fetches allocate (setting both locks freezes the cache contents);
- a write-through mode, which forwards every write and keeps lines clean;
- a flush-assist mode, which forces every missing cast-out to allocate whatever its coherence bit says.

The tag array, victim selection and bus protocol sit outside the block. The decision is registered once by default (parameter `OUT_REG`), so each answer appears one clock after its request.

Top module: `l2_alloc_filter`

## Requirements
- R1: With `cfg_enable` low, a valid request gives `rsp_alloc`=0, `rsp_to_bus`=1 and `rsp_dirty`=0.
- R2: A hit (`req_hit`=1) never allocates, whatever the lock bits are. A read hit is not forwarded and not marked dirty.
- R3: With only `cfg_data_only` set, an instruction-fetch miss (`req_src`=0) does not allocate. Data misses (`req_src`=1) do allocate, and cast-out misses (`req_src`=2) allocate subject to R6 and R7.
- R4: With only `cfg_instr_only` set, only instruction-fetch misses allocate. Data misses and cast-out misses do not.
- R5: With both `cfg_data_only` and `cfg_instr_only` set, no request allocates.
- R6: With `cfg_flush_assist` low, a cast-out miss whose coherence bit `req_cbit` is 0 does not allocate. With `req_cbit`=1 it allocates unless a lock forbids it.
- R7: With `cfg_flush_assist` high, every cast-out miss that no lock forbids allocates, regardless of `req_cbit`.
- R8: With `cfg_write_thru` set and the cache enabled, every write (`req_write`=1) gives `rsp_to_bus`=1 and `rsp_dirty`=0.
- R9: With `cfg_write_thru` clear, a write that hits or allocates gives `rsp_dirty`=1 and `rsp_to_bus`=0. A write miss that does not allocate goes to the bus and stays clean.
- R10: A read miss (`req_write`=0) always gives `rsp_to_bus`=1 and never `rsp_dirty`.
- R11: The reserved source code `req_src`=3 never allocates. It is still routed to the bus on a miss or a write-through write.
- R12: `rsp_valid` equals `req_valid` delayed by `OUT_REG` cycles. It is 0 after reset. While `rsp_valid` is 0, `rsp_alloc`, `rsp_to_bus` and `rsp_dirty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | 2 | Source: 0 fetch, 1 data load/store, 2 data cast-out, 3 reserved |
| req_hit | input | 1 | Lookup hit |
| req_cbit | input | 1 | Coherence bit of a cast-out line |
| req_write | input | 1 | Request writes the cache line |
| cfg_enable | input | 1 | Cache enable |
| cfg_data_only | input | 1 | Only data-side traffic may allocate |
| cfg_instr_only | input | 1 | Only instruction fetches may allocate |
| cfg_write_thru | input | 1 | Write-through mode |
| cfg_flush_assist | input | 1 | Cast-out misses allocate regardless of coherence bit |
| rsp_valid | output | 1 | Decision valid |
| rsp_alloc | output | 1 | Allocate a new line |
| rsp_to_bus | output | 1 | Forward the request to the system bus |
| rsp_dirty | output | 1 | Line written is marked dirty |

## Verification
The assertions assume that the request fields and the configuration bits are fully defined while `req_valid` is high. They also assume that the configuration changes only between requests, which is legal because the filter samples it together with the request. The bench drives every field at the falling edge, so each request is presented together with the configuration that applies to it. It sweeps all 1024 combinations of source, hit, coherence bit, write flag and control bits, including the reserved source code and the doubly locked setting. Idle cycles are interleaved so that the quiet-output rule is observed between requests as well.

// File: rtl/l2_alloc_pkg.sv
package l2_alloc_pkg;
   localparam int SRC_W = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_FETCH  = 2'd0,
      SRC_DATA   = 2'd1,
      SRC_CAST   = 2'd2,
      SRC_RSVD   = 2'd3
   } src_e;

   typedef struct packed {
      logic alloc;
      logic to_bus;
      logic dirty;
   } verdict_t;
endpackage

// File: rtl/l2_alloc_src_gate.sv
// Source-based allocation permission from the two lock bits.
module l2_alloc_src_gate
   import l2_alloc_pkg::*;
(
   input  logic [SRC_W-1:0] src,
   input  logic             data_only,
   input  logic             instr_only,
   output logic             permit
);
   src_e s;
   assign s = src_e'(src);

   always_comb begin
      unique case (s)
         SRC_FETCH: permit = !data_only;
         SRC_DATA,
         SRC_CAST:  permit = !instr_only;
         default:   permit = 1'b0;
      endcase
   end
endmodule

// File: rtl/l2_alloc_cast_gate.sv
// Coherence-bit gate for cast-outs, overridden by flush assist.
module l2_alloc_cast_gate
   import l2_alloc_pkg::*;
(
   input  logic [SRC_W-1:0] src,
   input  logic             cbit,
   input  logic             flush_assist,
   output logic             cast_ok
);
   logic is_cast;
   assign is_cast = (src_e'(src) == SRC_CAST);
   assign cast_ok = !is_cast || cbit || flush_assist;
endmodule

// File: rtl/l2_alloc_write_policy.sv
// Bus routing and dirty marking from hit/alloc and write mode.
module l2_alloc_write_policy (
   input  logic enable,
   input  logic hit,
   input  logic alloc,
   input  logic write,
   input  logic write_thru,
   output logic to_bus,
   output logic dirty
);
   logic resident;
   assign resident = enable && (hit || alloc);

   always_comb begin
      if (!enable) begin
         to_bus = 1'b1;
         dirty  = 1'b0;
      end else if (write) begin
         to_bus = write_thru || !resident;
         dirty  = !write_thru && resident;
      end else begin
         to_bus = !hit;
         dirty  = 1'b0;
      end
   end
endmodule

// File: rtl/l2_alloc_filter.sv
module l2_alloc_filter
   import l2_alloc_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_src,
   input  logic             req_hit,
   input  logic             req_cbit,
   input  logic             req_write,
   input  logic             cfg_enable,
   input  logic             cfg_data_only,
   input  logic             cfg_instr_only,
   input  logic             cfg_write_thru,
   input  logic             cfg_flush_assist,
   output logic             rsp_valid,
   output logic             rsp_alloc,
   output logic             rsp_to_bus,
   output logic             rsp_dirty
);
   localparam bit REGISTERED = (OUT_REG == 1);

   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out_reg
      $error("l2_alloc_filter: OUT_REG must be 0 or 1");
   end
   if (SRC_W != 2) begin : g_bad_src_w
      $error("l2_alloc_filter: source field must be 2 bits");
   end

   logic     permit;
   logic     cast_ok;
   logic     alloc_d;
   verdict_t v_d;
   verdict_t v_gated;

   l2_alloc_src_gate u_src (
      .src        (req_src),
      .data_only  (cfg_data_only),
      .instr_only (cfg_instr_only),
      .permit     (permit)
   );

   l2_alloc_cast_gate u_cast (
      .src          (req_src),
      .cbit         (req_cbit),
      .flush_assist (cfg_flush_assist),
      .cast_ok      (cast_ok)
   );

   assign alloc_d = cfg_enable && !req_hit && permit && cast_ok;

   l2_alloc_write_policy u_wr (
      .enable     (cfg_enable),
      .hit        (req_hit),
      .alloc      (alloc_d),
      .write      (req_write),
      .write_thru (cfg_write_thru),
      .to_bus     (v_d.to_bus),
      .dirty      (v_d.dirty)
   );
   assign v_d.alloc = alloc_d;

   assign v_gated = req_valid ? v_d : '0;

   if (REGISTERED) begin : g_reg
      logic     vld_q;
      verdict_t v_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            v_q   <= '0;
         end else begin
            vld_q <= req_valid;
            v_q   <= v_gated;
         end
      end
      assign rsp_valid  = vld_q;
      assign rsp_alloc  = v_q.alloc;
      assign rsp_to_bus = v_q.to_bus;
      assign rsp_dirty  = v_q.dirty;
   end else begin : g_comb
      assign rsp_valid  = req_valid;
      assign rsp_alloc  = v_gated.alloc;
      assign rsp_to_bus = v_gated.to_bus;
      assign rsp_dirty  = v_gated.dirty;
   end
endmodule

module l2_alloc_filter_chk #(
   parameter int LAT = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_src,
   input logic       req_hit,
   input logic       req_cbit,
   input logic       req_write,
   input logic       cfg_enable,
   input logic       cfg_data_only,
   input logic       cfg_instr_only,
   input logic       cfg_write_thru,
   input logic       cfg_flush_assist,
   input logic       rsp_valid,
   input logic       rsp_alloc,
   input logic       rsp_to_bus,
   input logic       rsp_dirty
);
   logic [10:0] cap;

   if (LAT == 1) begin : g_cap_reg
      always_ff @(posedge clk) begin
         if (!rst_n) cap <= '0;
         else cap <= {req_valid, req_src, req_hit, req_cbit, req_write,
                      cfg_enable, cfg_data_only, cfg_instr_only,
                      cfg_write_thru, cfg_flush_assist};
      end
   end else begin : g_cap_comb
      assign cap = {req_valid, req_src, req_hit, req_cbit, req_write,
                    cfg_enable, cfg_data_only, cfg_instr_only,
                    cfg_write_thru, cfg_flush_assist};
   end

   logic       c_vld, c_hit, c_cbit, c_wr, c_en, c_do, c_io, c_wt, c_fa;
   logic [1:0] c_src;
   assign {c_vld, c_src, c_hit, c_cbit, c_wr, c_en, c_do, c_io, c_wt, c_fa} = cap;

   // R1
   disabled_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !c_en |-> !rsp_alloc && rsp_to_bus && !rsp_dirty);
   // R2
   hit_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && c_hit |-> !rsp_alloc);
   // R5
   locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && c_do && c_io |-> !rsp_alloc);
   // R6
   cbit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && c_src == 2'd2 && !c_cbit && !c_fa |-> !rsp_alloc);
   // R8
   write_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && c_en && c_wt && c_wr |-> rsp_to_bus && !rsp_dirty);
   // R11
   reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && c_src == 2'd3 |-> !rsp_alloc);
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_alloc && !rsp_to_bus && !rsp_dirty);
   // R12
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == c_vld);
endmodule

bind l2_alloc_filter l2_alloc_filter_chk #(.LAT(OUT_REG)) u_chk (.*);

// File: tb/l2_alloc_filter_test.sv
module l2_alloc_filter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_src = '0;
   logic       req_hit = 1'b0, req_cbit = 1'b0, req_write = 1'b0;
   logic       cfg_enable = 1'b0, cfg_data_only = 1'b0, cfg_instr_only = 1'b0;
   logic       cfg_write_thru = 1'b0, cfg_flush_assist = 1'b0;
   logic       rsp_valid, rsp_alloc, rsp_to_bus, rsp_dirty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   l2_alloc_filter #(.OUT_REG(1)) uut (.*);

   // expected: {valid, alloc, to_bus, dirty}
   logic [3:0] exp_q[$];
   string      tag_q[$];

   function automatic logic [3:0] model(input logic v, input int src,
      input logic hit, input logic cb, input logic wr, input logic en,
      input logic dO, input logic iO, input logic wt, input logic fa);
      logic may, al, bus, dy;
      if (!v) return 4'b0000;
      if (!en) return 4'b1010;
      may = 1'b0;
      if (!hit) begin
         if (src == 0) may = !dO;
         else if (src == 1) may = !iO;
         else if (src == 2) may = !iO && (cb || fa);
      end
      al = may;
      if (wr) begin
         if (wt) begin bus = 1'b1; dy = 1'b0; end
         else if (hit || al) begin bus = 1'b0; dy = 1'b1; end
         else begin bus = 1'b1; dy = 1'b0; end
      end else begin
         bus = !hit; dy = 1'b0;
      end
      return {1'b1, al, bus, dy};
   endfunction

   function automatic string pick_tag(input logic v, input int src,
      input logic hit, input logic wr, input logic en, input logic dO,
      input logic iO, input logic wt, input logic fa);
      if (!v) return "R12";
      if (!en) return "R1";
      if (src == 3) return "R11";
      if (hit) return wr ? (wt ? "R8" : "R9") : "R2";
      if (dO && iO) return "R5";
      if (dO) return "R3";
      if (iO) return "R4";
      if (src == 2) return fa ? "R7" : "R6";
      if (wr) return wt ? "R8" : "R9";
      return "R10";
   endfunction

   task automatic compare(input logic [3:0] e, input string t);
      logic [3:0] a;
      a = {rsp_valid, rsp_alloc, rsp_to_bus, rsp_dirty};
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s: got v/al/bus/dy=%b expected %b", t, a, e);
      end
   endtask

   // one cycle: check the previous request's result, then drive the next
   task automatic step(input logic v, input int src, input logic hit,
      input logic cb, input logic wr, input logic en, input logic dO,
      input logic iO, input logic wt, input logic fa);
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
      req_valid = v; req_src = src[1:0]; req_hit = hit; req_cbit = cb;
      req_write = wr; cfg_enable = en; cfg_data_only = dO;
      cfg_instr_only = iO; cfg_write_thru = wt; cfg_flush_assist = fa;
      exp_q.push_back(model(v, src, hit, cb, wr, en, dO, iO, wt, fa));
      tag_q.push_back(pick_tag(v, src, hit, wr, en, dO, iO, wt, fa));
   endtask

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      compare(4'b0000, "R12");
      rst_n = 1'b1;
      // directed corners
      step(1, 0, 0, 0, 0, 1, 1, 0, 0, 0); // R3 fetch miss, data-only
      step(1, 1, 0, 0, 1, 1, 1, 0, 0, 0); // R3/R9 data write miss allocates dirty
      step(1, 1, 0, 0, 0, 1, 0, 1, 0, 0); // R4 data miss blocked
      step(1, 0, 0, 0, 0, 1, 0, 1, 0, 0); // R4 fetch miss allocates
      step(1, 0, 0, 0, 0, 1, 1, 1, 0, 0); // R5 locked
      step(1, 2, 0, 0, 1, 1, 0, 0, 0, 0); // R6 cbit clear
      step(1, 2, 0, 1, 1, 1, 0, 0, 0, 0); // R6 cbit set
      step(1, 2, 0, 0, 1, 1, 0, 0, 0, 1); // R7 flush assist
      step(1, 1, 1, 0, 1, 1, 0, 0, 1, 0); // R8 write-through hit
      step(0, 1, 1, 0, 1, 1, 0, 0, 1, 0); // R12 idle
      step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0); // R10 read miss
      step(1, 3, 0, 1, 1, 1, 0, 0, 0, 1); // R11 reserved source
      step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0); // R1 disabled
      // exhaustive sweep with idle cycles interleaved
      for (int i = 0; i < 1024; i++) begin
         step(1, i & 3, i[2], i[3], i[4], i[5], i[6], i[7], i[8], i[9]);
         if ((i % 7) == 0) step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R12: watchdog expired, got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule